// File: doc/BRIEF.md
# Cluster Overlap Filter

This block takes one 2x2 tower cluster and the eight clusters whose origins sit one tower away from it. It decides which of the central cluster's four towers the central cluster may keep. Overlapping clusters compete for their common towers. When a neighbour has more energy, the central cluster gives up the towers it shares with that neighbour. The block then adds up the towers that are left, passes on the central record's fine-grain and e/γ bits, and reports whether the cluster came through whole. A weak result is cleared to zero.

Each neighbour is filtered by its own copy of this block, where that neighbour is the centre, so this block never changes a neighbour's record. Ties are settled by direction, so that exactly one of two equal clusters claims the towers they share. The datapath is a five-stage pipeline with a valid bit alongside it. It accepts a new set of nine records on every clock cycle.

Top module: `cluster_overlap_filter`

## Requirements
- R1: Each record is 38 bits wide. Bits [8:0] hold the origin tower energy, [17:9] the east tower, [26:18] the south tower, [35:27] the south-east tower, bit 36 the fine-grain flag and bit 37 the e/γ flag. The energy of a cluster is the unsigned 11-bit sum of its four towers, so the largest value, 2044, does not wrap.
- R2: A neighbour to the north, north-east, west or north-west beats the central cluster only when its energy is strictly greater than the central energy. On a tie the central cluster keeps the towers.
- R3: A neighbour to the east, south-east, south or south-west beats the central cluster when its energy is greater than or equal to the central energy.
- R4: The central cluster loses the towers it shares with every neighbour that beats it. The north neighbour shares origin and east, south shares south and south-east, east shares east and south-east, west shares origin and south, north-east shares east only, north-west origin only, south-east south-east only, and south-west south only. The output energy is the sum of the towers that remain.
- R5: The central flag is 1 only when the central cluster lost no tower.
- R6: The result is 14 bits wide: [10:0] energy, bit 11 fine-grain, bit 12 e/γ, bit 13 central flag. Both flag bits are copied from the central record, and the neighbour records' flag bits have no effect.
- R7: When the pruned energy is less than or equal to THRESHOLD (default 16), all 14 result bits are 0.
- R8: A record set presented with inValid high appears on result with outValid high exactly five clock edges later. Back-to-back sets stream at one per cycle.
- R9: Reset clears result and outValid to 0 and empties the pipeline. While no valid set reaches the output stage, result holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks the nine records as a set to process |
| centreRec | input | 38 | Record of the central cluster |
| northRec | input | 38 | Record of the north neighbour |
| northEastRec | input | 38 | Record of the north-east neighbour |
| eastRec | input | 38 | Record of the east neighbour |
| southEastRec | input | 38 | Record of the south-east neighbour |
| southRec | input | 38 | Record of the south neighbour |
| southWestRec | input | 38 | Record of the south-west neighbour |
| westRec | input | 38 | Record of the west neighbour |
| northWestRec | input | 38 | Record of the north-west neighbour |
| outValid | output | 1 | Result carries a processed set |
| result | output | 14 | Energy, fine-grain, e/γ and central flag |

## Verification
The assertions assume that inValid is a clean level with no X, and that reset is released only away from a clock edge. They also assume that every record holds unsigned tower energies, so the 11-bit sums cannot wrap. The stimulus meets these assumptions. It drives inputs only on the falling clock edge, keeps every tower at or below 511, and builds each neighbour's energy by filling its towers in order up to that limit. The tie checks for the north and south neighbours rely on the stimulus creating exact ties, and the stimulus table contains such ties on purpose.

// File: rtl/cof_pkg.sv
package cof_pkg;

  localparam int NUM_DIRS   = 8;
  localparam int NUM_TOWERS = 4;
  localparam int PIPE_DEPTH = 5;

  // Neighbour order used by every packed neighbour array.
  typedef enum logic [2:0] {
    DIR_N  = 3'd0,
    DIR_NE = 3'd1,
    DIR_E  = 3'd2,
    DIR_SE = 3'd3,
    DIR_S  = 3'd4,
    DIR_SW = 3'd5,
    DIR_W  = 3'd6,
    DIR_NW = 3'd7
  } dir_e;

  // One load enable per pipeline stage.
  typedef struct packed {
    logic s1;
    logic s2;
    logic s3;
    logic s4;
    logic s5;
  } stageStrobe_t;

  // Central towers covered by a neighbour.
  // Bit 0 origin, bit 1 east, bit 2 south, bit 3 south-east.
  function automatic logic [NUM_TOWERS-1:0] sharedMask(input int dir);
    logic [NUM_TOWERS-1:0] m;
    case (dir)
      0:       m = 4'b0011;
      1:       m = 4'b0010;
      2:       m = 4'b1010;
      3:       m = 4'b1000;
      4:       m = 4'b1100;
      5:       m = 4'b0100;
      6:       m = 4'b0101;
      7:       m = 4'b0001;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

  // Directions that win a tie: east, south-east, south, south-west.
  function automatic logic tieToNeighbour(input int dir);
    return (dir >= 2) && (dir <= 5);
  endfunction

endpackage

// File: rtl/cof_cluster_sum.sv
module cof_cluster_sum
  import cof_pkg::*;
#(
  parameter  int TOWER_W = 9,
  localparam int SUM_W   = TOWER_W + $clog2(NUM_TOWERS)
) (
  input  logic [NUM_TOWERS*TOWER_W-1:0] towers,
  input  logic [NUM_TOWERS-1:0]         keep,
  output logic [SUM_W-1:0]              sum
);

  // Adds up the kept towers, widened so the sum never wraps.
  always_comb begin
    sum = '0;
    for (int k = 0; k < NUM_TOWERS; k++) begin
      if (keep[k]) begin
        sum = sum + SUM_W'(towers[k*TOWER_W +: TOWER_W]);
      end
    end
  end

endmodule

// File: rtl/cof_control.sv
module cof_control
  import cof_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);

  logic [PIPE_DEPTH-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[PIPE_DEPTH-2:0], inValid};
    end
  end

  // Each stage loads only when its upstream neighbour holds live data.
  always_comb begin
    strobe.s1 = inValid;
    strobe.s2 = validPipe[0];
    strobe.s3 = validPipe[1];
    strobe.s4 = validPipe[2];
    strobe.s5 = validPipe[3];
  end

  assign outValid = validPipe[PIPE_DEPTH-1];

  AST_LATENCY_FIVE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##5 outValid); // R8

endmodule

// File: rtl/cof_datapath.sv
module cof_datapath
  import cof_pkg::*;
#(
  parameter  int TOWER_W   = 9,
  parameter  int THRESHOLD = 16,
  localparam int TW_ALL    = NUM_TOWERS * TOWER_W,
  localparam int REC_W     = TW_ALL + 2,
  localparam int SUM_W     = TOWER_W + $clog2(NUM_TOWERS),
  localparam int RESULT_W  = SUM_W + 3
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  stageStrobe_t                         strobe,
  input  logic [REC_W-1:0]                     centreRec,
  input  logic [NUM_DIRS-1:0][TW_ALL-1:0]      nbrTowers,
  output logic [RESULT_W-1:0]                  result
);

  localparam int FG_BIT = TW_ALL;
  localparam int EG_BIT = TW_ALL + 1;
  localparam logic [SUM_W-1:0]      THR      = SUM_W'(THRESHOLD);
  localparam logic [NUM_TOWERS-1:0] ALL_KEEP = '1;

  // ---------------- stage 1: cluster energies ----------------
  logic [NUM_DIRS-1:0][SUM_W-1:0] nbrSumNext;
  logic [SUM_W-1:0]               centreSumNext;
  logic [NUM_DIRS-1:0][SUM_W-1:0] nbrSumS1;
  logic [SUM_W-1:0]               centreSumS1;
  logic [REC_W-1:0]               centreRecS1;

  cof_cluster_sum #(.TOWER_W(TOWER_W)) i_centreSum (
    .towers (centreRec[TW_ALL-1:0]),
    .keep   (ALL_KEEP),
    .sum    (centreSumNext)
  );

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_nbrSum
    cof_cluster_sum #(.TOWER_W(TOWER_W)) i_nbrSum (
      .towers (nbrTowers[d]),
      .keep   (ALL_KEEP),
      .sum    (nbrSumNext[d])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nbrSumS1    <= '0;
      centreSumS1 <= '0;
      centreRecS1 <= '0;
    end else if (strobe.s1) begin
      nbrSumS1    <= nbrSumNext;
      centreSumS1 <= centreSumNext;
      centreRecS1 <= centreRec;
    end
  end

  // ---------------- stage 2: strength comparison ----------------
  logic [NUM_DIRS-1:0] strongerNext;
  logic [NUM_DIRS-1:0] strongerS2;
  logic [SUM_W-1:0]    centreSumS2;
  logic [REC_W-1:0]    centreRecS2;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_cmp
    if (tieToNeighbour(d)) begin : g_tieWins
      assign strongerNext[d] = (centreSumS1 <= nbrSumS1[d]);
    end else begin : g_strict
      assign strongerNext[d] = (centreSumS1 < nbrSumS1[d]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strongerS2  <= '0;
      centreSumS2 <= '0;
      centreRecS2 <= '0;
    end else if (strobe.s2) begin
      strongerS2  <= strongerNext;
      centreSumS2 <= centreSumS1;
      centreRecS2 <= centreRecS1;
    end
  end

  // ---------------- stage 3: tower keep mask ----------------
  logic [NUM_TOWERS-1:0] lostNext;
  logic [NUM_TOWERS-1:0] keepS3;
  logic [SUM_W-1:0]      centreSumS3;
  logic [REC_W-1:0]      centreRecS3;

  always_comb begin
    lostNext = '0;
    for (int d = 0; d < NUM_DIRS; d++) begin
      if (strongerS2[d]) begin
        lostNext = lostNext | sharedMask(d);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keepS3      <= '0;
      centreSumS3 <= '0;
      centreRecS3 <= '0;
    end else if (strobe.s3) begin
      keepS3      <= ~lostNext;
      centreSumS3 <= centreSumS2;
      centreRecS3 <= centreRecS2;
    end
  end

  // ---------------- stage 4: pruned energy ----------------
  logic [SUM_W-1:0] prunedSum;
  logic [SUM_W-1:0] energyS4;
  logic             centralS4;
  logic             fgS4;
  logic             egS4;

  cof_cluster_sum #(.TOWER_W(TOWER_W)) i_prunedSum (
    .towers (centreRecS3[TW_ALL-1:0]),
    .keep   (keepS3),
    .sum    (prunedSum)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      energyS4  <= '0;
      centralS4 <= 1'b0;
      fgS4      <= 1'b0;
      egS4      <= 1'b0;
    end else if (strobe.s4) begin
      energyS4  <= prunedSum;
      centralS4 <= &keepS3;
      fgS4      <= centreRecS3[FG_BIT];
      egS4      <= centreRecS3[EG_BIT];
    end
  end

  // ---------------- stage 5: threshold and output ----------------
  logic [RESULT_W-1:0] resultNext;
  logic [RESULT_W-1:0] resultQ;

  always_comb begin
    if (energyS4 > THR) begin
      resultNext = {centralS4, egS4, fgS4, energyS4};
    end else begin
      resultNext = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (strobe.s5) begin
      resultQ <= resultNext;
    end
  end

  assign result = resultQ;

  // ---------------- assertions ----------------
  AST_EQUAL_NORTH_LOSES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.s2 |=> (($past(centreSumS1) != $past(nbrSumS1[DIR_N])) || !strongerS2[DIR_N])); // R2

  AST_EQUAL_SOUTH_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.s2 |=> (($past(centreSumS1) != $past(nbrSumS1[DIR_S])) || strongerS2[DIR_S])); // R3

  AST_PRUNE_NOT_GROW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.s4 |=> (energyS4 <= $past(centreSumS3))); // R4

  AST_CENTRAL_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.s4 |=> (!centralS4 || (energyS4 == $past(centreSumS3)))); // R5

  AST_ABOVE_THRESHOLD: assert property (@(posedge clk) disable iff (!rstN)
    (resultQ != '0) |-> (resultQ[SUM_W-1:0] > THR)); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.s5 |=> $stable(resultQ)); // R9

endmodule

// File: rtl/cluster_overlap_filter.sv
module cluster_overlap_filter
  import cof_pkg::*;
#(
  parameter  int TOWER_W   = 9,
  parameter  int THRESHOLD = 16,
  localparam int TW_ALL    = NUM_TOWERS * TOWER_W,
  localparam int REC_W     = TW_ALL + 2,
  localparam int RESULT_W  = TOWER_W + $clog2(NUM_TOWERS) + 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [REC_W-1:0]    centreRec,
  input  logic [REC_W-1:0]    northRec,
  input  logic [REC_W-1:0]    northEastRec,
  input  logic [REC_W-1:0]    eastRec,
  input  logic [REC_W-1:0]    southEastRec,
  input  logic [REC_W-1:0]    southRec,
  input  logic [REC_W-1:0]    southWestRec,
  input  logic [REC_W-1:0]    westRec,
  input  logic [REC_W-1:0]    northWestRec,
  output logic                outValid,
  output logic [RESULT_W-1:0] result
);

  stageStrobe_t                    strobe;
  logic [NUM_DIRS-1:0][TW_ALL-1:0] nbrTowers;
  logic                            unusedNbrFlags;

  // Only the tower energies of the neighbours matter here.
  always_comb begin
    nbrTowers[DIR_N]  = northRec[TW_ALL-1:0];
    nbrTowers[DIR_NE] = northEastRec[TW_ALL-1:0];
    nbrTowers[DIR_E]  = eastRec[TW_ALL-1:0];
    nbrTowers[DIR_SE] = southEastRec[TW_ALL-1:0];
    nbrTowers[DIR_S]  = southRec[TW_ALL-1:0];
    nbrTowers[DIR_SW] = southWestRec[TW_ALL-1:0];
    nbrTowers[DIR_W]  = westRec[TW_ALL-1:0];
    nbrTowers[DIR_NW] = northWestRec[TW_ALL-1:0];
  end

  assign unusedNbrFlags = ^{northRec[REC_W-1:TW_ALL], northEastRec[REC_W-1:TW_ALL],
                            eastRec[REC_W-1:TW_ALL], southEastRec[REC_W-1:TW_ALL],
                            southRec[REC_W-1:TW_ALL], southWestRec[REC_W-1:TW_ALL],
                            westRec[REC_W-1:TW_ALL], northWestRec[REC_W-1:TW_ALL]};

  cof_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  cof_datapath #(
    .TOWER_W   (TOWER_W),
    .THRESHOLD (THRESHOLD)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .centreRec (centreRec),
    .nbrTowers (nbrTowers),
    .result    (result)
  );

endmodule

// File: tb/test_cluster_overlap_filter.sv
`timescale 1ns/1ps
module test_cluster_overlap_filter;

  localparam int NVEC = 14;

  typedef struct packed {
    logic [8:0]  t1;
    logic [8:0]  t2;
    logic [8:0]  t3;
    logic [8:0]  t4;
    logic        fg;
    logic        eg;
    logic [10:0] nN;
    logic [10:0] nNE;
    logic [10:0] nE;
    logic [10:0] nSE;
    logic [10:0] nS;
    logic [10:0] nSW;
    logic [10:0] nW;
    logic [10:0] nNW;
    logic [10:0] expE;
    logic        expFg;
    logic        expEg;
    logic        expCentral;
  } vec_t;

  // towers(origin,east,south,se), fg, eg, neighbours N NE E SE S SW W NW, expected energy, fg, eg, central
  localparam vec_t VECS [NVEC] = '{
    '{9'd10, 9'd20, 9'd30, 9'd40, 1'b1, 1'b0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd100, 1'b1, 1'b0, 1'b1},
    '{9'd10, 9'd20, 9'd30, 9'd40, 1'b1, 1'b0, 11'd100, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd100, 1'b1, 1'b0, 1'b1},
    '{9'd10, 9'd20, 9'd30, 9'd40, 1'b1, 1'b0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd100, 11'd0, 11'd0, 11'd0, 11'd30, 1'b1, 1'b0, 1'b0},
    '{9'd10, 9'd20, 9'd30, 9'd40, 1'b1, 1'b0, 11'd101, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd70, 1'b1, 1'b0, 1'b0},
    '{9'd10, 9'd20, 9'd30, 9'd40, 1'b1, 1'b0, 11'd0, 11'd0, 11'd100, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd40, 1'b1, 1'b0, 1'b0},
    '{9'd10, 9'd20, 9'd30, 9'd40, 1'b1, 1'b0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd100, 11'd0, 11'd100, 1'b1, 1'b0, 1'b1},
    '{9'd10, 9'd20, 9'd30, 9'd40, 1'b1, 1'b0, 11'd0, 11'd100, 11'd0, 11'd100, 11'd0, 11'd100, 11'd0, 11'd100, 11'd30, 1'b1, 1'b0, 1'b0},
    '{9'd10, 9'd20, 9'd30, 9'd40, 1'b1, 1'b0, 11'd0, 11'd200, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd200, 11'd70, 1'b1, 1'b0, 1'b0},
    '{9'd10, 9'd20, 9'd30, 9'd40, 1'b1, 1'b0, 11'd2000, 11'd2000, 11'd2000, 11'd2000, 11'd2000, 11'd2000, 11'd2000, 11'd2000, 11'd0, 1'b0, 1'b0, 1'b0},
    '{9'd4, 9'd4, 9'd4, 9'd4, 1'b1, 1'b1, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 1'b0, 1'b0, 1'b0},
    '{9'd4, 9'd4, 9'd4, 9'd5, 1'b1, 1'b1, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd17, 1'b1, 1'b1, 1'b1},
    '{9'd10, 9'd5, 9'd5, 9'd5, 1'b0, 1'b1, 11'd0, 11'd0, 11'd30, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 1'b0, 1'b0, 1'b0},
    '{9'd10, 9'd20, 9'd30, 9'd40, 1'b0, 1'b1, 11'd0, 11'd0, 11'd0, 11'd99, 11'd0, 11'd0, 11'd101, 11'd0, 11'd60, 1'b0, 1'b1, 1'b0},
    '{9'd511, 9'd511, 9'd511, 9'd511, 1'b0, 1'b1, 11'd2044, 11'd0, 11'd0, 11'd0, 11'd2043, 11'd0, 11'd0, 11'd0, 11'd2044, 1'b0, 1'b1, 1'b1}
  };

  logic        clk;
  logic        rstN;
  logic        inValid;
  logic [37:0] centreRec, northRec, northEastRec, eastRec, southEastRec;
  logic [37:0] southRec, southWestRec, westRec, northWestRec;
  logic        outValid;
  logic [13:0] result;

  int  testCount = 0;
  int  failCount = 0;
  bit  finished  = 1'b0;

  cluster_overlap_filter i_cluster_overlap_filter (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .centreRec    (centreRec),
    .northRec     (northRec),
    .northEastRec (northEastRec),
    .eastRec      (eastRec),
    .southEastRec (southEastRec),
    .southRec     (southRec),
    .southWestRec (southWestRec),
    .westRec      (westRec),
    .northWestRec (northWestRec),
    .outValid     (outValid),
    .result       (result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string reqTag(input int i);
    case (i)
      0:  return "R1 R5 R6 full cluster kept";
      1:  return "R2 north tie keeps towers";
      2:  return "R3 R4 south tie takes south towers";
      3:  return "R2 R4 stronger north";
      4:  return "R3 R4 east tie";
      5:  return "R2 west tie keeps towers";
      6:  return "R2 R3 R4 diagonal ties";
      7:  return "R2 R4 stronger diagonals";
      8:  return "R4 R7 every tower pruned";
      9:  return "R7 energy equals threshold";
      10: return "R6 R7 energy one above threshold";
      11: return "R4 R7 pruning drops below threshold";
      12: return "R2 R3 R4 west wins, weaker south-east";
      default: return "R1 R3 maximum energy";
    endcase
  endfunction

  // Neighbour record of a given energy. Its flag bits are set to show they are ignored (R6).
  function automatic logic [37:0] mkNbr(input logic [10:0] e);
    logic [8:0] t [4];
    int rest;
    rest = int'(e);
    for (int k = 0; k < 4; k++) begin
      if (rest > 511) begin
        t[k] = 9'd511;
        rest = rest - 511;
      end else begin
        t[k] = 9'(rest);
        rest = 0;
      end
    end
    return {2'b11, t[3], t[2], t[1], t[0]};
  endfunction

  function automatic logic [13:0] expOf(input vec_t v);
    return {v.expCentral, v.expEg, v.expFg, v.expE};
  endfunction

  task automatic applyVec(input vec_t v);
    centreRec    = {v.eg, v.fg, v.t4, v.t3, v.t2, v.t1};
    northRec     = mkNbr(v.nN);
    northEastRec = mkNbr(v.nNE);
    eastRec      = mkNbr(v.nE);
    southEastRec = mkNbr(v.nSE);
    southRec     = mkNbr(v.nS);
    southWestRec = mkNbr(v.nSW);
    westRec      = mkNbr(v.nW);
    northWestRec = mkNbr(v.nNW);
    inValid      = 1'b1;
  endtask

  task automatic goIdle();
    inValid = 1'b0;
  endtask

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Watchdog: a hung run counts as one failed check.
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    inValid = 1'b0;
    centreRec = '0; northRec = '0; northEastRec = '0; eastRec = '0; southEastRec = '0;
    southRec = '0; southWestRec = '0; westRec = '0; northWestRec = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state (R9)
    @(negedge clk);
    check("R9 reset result", result, 14'h0);
    check("R9 reset outValid", 14'(outValid), 14'h0);

    // Single set: latency of exactly five edges (R8), then hold (R9)
    @(negedge clk);
    applyVec(VECS[0]);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) goIdle();
      if (k == 4) check("R8 outValid not yet", 14'(outValid), 14'h0);
      if (k == 5) begin
        check("R8 outValid after five edges", 14'(outValid), 14'h1);
        check("R8 R1 result after five edges", result, expOf(VECS[0]));
      end
      if (k == 6) begin
        check("R8 outValid single pulse", 14'(outValid), 14'h0);
        check("R9 result held", result, expOf(VECS[0]));
      end
    end

    // Back-to-back stream through the vector table
    for (int i = 0; i <= NVEC + 4; i++) begin
      @(negedge clk);
      if (i >= 5) begin
        check(reqTag(i - 5), result, expOf(VECS[i - 5]));
        check("R8 outValid while streaming", 14'(outValid), 14'h1);
      end
      if (i < NVEC) applyVec(VECS[i]);
      else goIdle();
    end

    // Idle: output holds the last result (R9)
    repeat (8) @(negedge clk);
    check("R9 hold after stream", result, expOf(VECS[NVEC - 1]));
    check("R9 outValid idle", 14'(outValid), 14'h0);

    // Reset in mid-flight flushes the pipeline (R9)
    applyVec(VECS[3]);
    @(negedge clk);
    goIdle();
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R9 async reset clears result", result, 14'h0);
    check("R9 async reset clears outValid", 14'(outValid), 14'h0);
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R9 pipeline flushed by reset", 14'(outValid), 14'h0);
    end
    check("R9 result zero after flush", result, 14'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule